// File: doc/BRIEF.md
# Transparent address translation matcher

This block decides whether a logical address lies in a window that bypasses paging. It keeps four 32-bit window registers: a pair that applies to instruction fetches and a pair that applies to data accesses. Each window names an 8-bit base for the top address byte, an 8-bit don't-care mask over that byte, an enable, a privilege filter and a write-protect flag. When an access lands in an enabled window of its own kind, the block reports a hit, hands back the logical address as the physical one (aligned to a page), and grants permissions. The page-table walk is then skipped.

Software reaches the windows through a small control-register port: a two-bit selector, a write strobe with write data, and a read-data output that always shows the selected window. The lookup itself is combinational, so the result of an access can be used in the same cycle that it is presented.

Top module: `tt_xlate_matcher`

## Requirements
- R1: A window register is chosen by `cr_sel`: 0 is data window 0, 1 is data window 1, 2 is instruction window 0, 3 is instruction window 1. With `cr_wr_en` high, `cr_wdata` is stored at the next rising clock edge, and `cr_rdata` shows the selected register's content in the same cycle.
- R2: Synchronous reset clears all four registers to zero, so every access misses after reset.
- R3: Bit 15 of a window is its enable; a window with bit 15 at 0 never matches.
- R4: Bits 14:13 of a window filter by privilege: 00 matches only accesses with `acc_super` low, 01 only accesses with `acc_super` high, 10 and 11 match both.
- R5: The address matches when `acc_addr[31:24]` equals the window's bits 31:24 at every position where the window's bits 23:16 hold a 0; a mask bit of 1 makes that position don't-care, and `acc_addr[23:0]` never affects matching.
- R6: An access with `acc_ifetch` high is compared only with the two instruction windows; an access with `acc_ifetch` low only with the two data windows.
- R7: Within the selected pair, window 0 has priority over window 1; the first window that matches alone sets the permissions.
- R8: On a hit, `phys_addr` equals `acc_addr` with its low 12 bits forced to zero; on a miss, `phys_addr` is zero.
- R9: On a hit, `perm_r` and `perm_x` are 1.
- R10: On a hit, `perm_w` is 1 exactly when bit 2 of the matching window is 0; on a miss, `perm_r`, `perm_w` and `perm_x` are all 0.
- R11: Outputs follow the access inputs within the same cycle; an access presented in the cycle of a register write is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cr_wr_en | input | 1 | Write strobe for the selected window register |
| cr_sel | input | 2 | Window register selector for write and read |
| cr_wdata | input | 32 | Data written to the selected window |
| cr_rdata | output | 32 | Content of the selected window |
| acc_addr | input | 32 | Logical address of the access |
| acc_super | input | 1 | 1 for a supervisor access, 0 for user |
| acc_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| hit | output | 1 | Address lies in a matching window |
| phys_addr | output | 32 | Page-aligned pass-through address on a hit, zero otherwise |
| perm_r | output | 1 | Read permission |
| perm_w | output | 1 | Write permission |
| perm_x | output | 1 | Execute permission |

## Verification
A register update and a lookup can share a cycle, and the lookup must then use the old window contents. The bench provokes this by raising the write strobe to enable a previously disabled window while presenting an access that only the new value would match, expecting a miss in that cycle and a hit in the next with the inputs held. It also rewrites the higher-priority window of a pair while both windows cover the same address, so the write permission reported flips only after the edge.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BASE_LO   = 24;
    localparam int unsigned MASK_LO   = 16;
    localparam int unsigned EN_BIT    = 15;
    localparam int unsigned MODE_LO   = 13;
    localparam int unsigned WP_BIT    = 2;

    typedef enum logic [1:0] {
        PRIV_USER_ONLY  = 2'b00,
        PRIV_SUPER_ONLY = 2'b01,
        PRIV_BOTH_A     = 2'b10,
        PRIV_BOTH_B     = 2'b11
    } tt_priv_e;

    typedef struct packed {
        logic [BYTE_W-1:0] base;
        logic [BYTE_W-1:0] dont_care;
        logic              enable;
        tt_priv_e          priv;
        logic              wprot;
    } tt_win_t;

    typedef struct packed {
        logic [BYTE_W-1:0] top_byte;
        logic              is_super;
    } tt_probe_t;

    function automatic tt_win_t tt_decode(input logic [REG_W-1:0] raw);
        tt_win_t w;
        w.base      = raw[BASE_LO +: BYTE_W];
        w.dont_care = raw[MASK_LO +: BYTE_W];
        w.enable    = raw[EN_BIT];
        w.priv      = tt_priv_e'(raw[MODE_LO +: 2]);
        w.wprot     = raw[WP_BIT];
        return w;
    endfunction

    function automatic logic tt_priv_ok(input tt_priv_e p, input logic is_super);
        logic ok;
        unique case (p)
            PRIV_USER_ONLY:  ok = !is_super;
            PRIV_SUPER_ONLY: ok = is_super;
            default:         ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tt_window_bank.sv
module tt_window_bank
    import tt_pkg::*;
#(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned SEL_W    = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              sel,
    input  logic [REG_W-1:0]              wr_data,
    output logic [REG_W-1:0]              rd_data,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_o
);

    logic [NUM_REGS-1:0][REG_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q[sel] <= wr_data;
        end
    end

    assign rd_data = store_q[sel];
    assign regs_o  = store_q;

endmodule

// File: rtl/tt_window_match.sv
module tt_window_match
    import tt_pkg::*;
(
    input  tt_win_t   win,
    input  tt_probe_t probe,
    output logic      match,
    output logic      wprot
);

    logic [BYTE_W-1:0] care;
    logic              addr_eq;

    always_comb begin
        care    = ~win.dont_care;
        addr_eq = ((probe.top_byte ^ win.base) & care) == '0;
        match   = win.enable && tt_priv_ok(win.priv, probe.is_super) && addr_eq;
        wprot   = win.wprot;
    end

endmodule

// File: rtl/tt_priority_pick.sv
module tt_priority_pick #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] match,
    input  logic [N-1:0] wprot,
    output logic         any_hit,
    output logic         sel_wprot
);

    always_comb begin
        any_hit   = 1'b0;
        sel_wprot = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit   = 1'b1;
                sel_wprot = wprot[i];
            end
        end
    end

endmodule

// File: rtl/tt_xlate_matcher.sv
module tt_xlate_matcher
    import tt_pkg::*;
#(
    parameter int unsigned PAGE_BITS    = 12,
    parameter int unsigned WIN_PER_KIND = 2,
    parameter int unsigned SEL_W        = $clog2(2 * WIN_PER_KIND)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cr_wr_en,
    input  logic [SEL_W-1:0] cr_sel,
    input  logic [31:0]      cr_wdata,
    output logic [31:0]      cr_rdata,
    input  logic [31:0]      acc_addr,
    input  logic             acc_super,
    input  logic             acc_ifetch,
    output logic             hit,
    output logic [31:0]      phys_addr,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x
);

    localparam int unsigned NUM_REGS = 2 * WIN_PER_KIND;
    localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

    logic [NUM_REGS-1:0][REG_W-1:0] win_q;
    logic [WIN_PER_KIND-1:0]        w_match;
    logic [WIN_PER_KIND-1:0]        w_prot;
    logic                           any_hit;
    logic                           sel_prot;
    tt_probe_t                      probe;

    tt_window_bank #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cr_wr_en),
        .sel     (cr_sel),
        .wr_data (cr_wdata),
        .rd_data (cr_rdata),
        .regs_o  (win_q)
    );

    assign probe.top_byte = acc_addr[BASE_LO +: BYTE_W];
    assign probe.is_super = acc_super;

    for (genvar g = 0; g < WIN_PER_KIND; g++) begin : g_slot
        tt_win_t slot_win;
        assign slot_win = acc_ifetch ? tt_decode(win_q[WIN_PER_KIND + g])
                                     : tt_decode(win_q[g]);
        tt_window_match u_match (
            .win   (slot_win),
            .probe (probe),
            .match (w_match[g]),
            .wprot (w_prot[g])
        );
    end

    tt_priority_pick #(
        .N (WIN_PER_KIND)
    ) u_pick (
        .match     (w_match),
        .wprot     (w_prot),
        .any_hit   (any_hit),
        .sel_wprot (sel_prot)
    );

    always_comb begin
        hit       = any_hit;
        phys_addr = any_hit ? (acc_addr & PAGE_MASK) : '0;
        perm_r    = any_hit;
        perm_x    = any_hit;
        perm_w    = any_hit && !sel_prot;
    end

endmodule

// File: rtl/tt_xlate_matcher_chk.sv
module tt_xlate_matcher_chk #(
    parameter int unsigned PAGE_BITS    = 12,
    parameter int unsigned WIN_PER_KIND = 2,
    parameter int unsigned SEL_W        = 2
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               cr_wr_en,
    input logic [SEL_W-1:0]                   cr_sel,
    input logic [31:0]                        cr_wdata,
    input logic [31:0]                        cr_rdata,
    input logic [31:0]                        acc_addr,
    input logic                               acc_ifetch,
    input logic                               hit,
    input logic [31:0]                        phys_addr,
    input logic                               perm_r,
    input logic                               perm_w,
    input logic                               perm_x,
    input logic [2*WIN_PER_KIND-1:0][31:0]    win_q
);

    localparam logic [31:0] LOW_MASK = (32'd1 << PAGE_BITS) - 32'd1;

    logic pair_has_enabled;
    logic pair_has_writable;

    always_comb begin
        pair_has_enabled  = 1'b0;
        pair_has_writable = 1'b0;
        for (int i = 0; i < WIN_PER_KIND; i++) begin
            if (acc_ifetch) begin
                pair_has_enabled  |= win_q[WIN_PER_KIND + i][15];
                pair_has_writable |= win_q[WIN_PER_KIND + i][15] && !win_q[WIN_PER_KIND + i][2];
            end else begin
                pair_has_enabled  |= win_q[i][15];
                pair_has_writable |= win_q[i][15] && !win_q[i][2];
            end
        end
    end

    assert_rw_roundtrip_R1: assert property (@(posedge clk) disable iff (rst)
        cr_wr_en |=> (cr_sel != $past(cr_sel)) || (cr_rdata == $past(cr_wdata)));

    assert_reset_miss_R2: assert property (@(posedge clk)
        rst |=> !hit);

    // R3 and R6: a hit needs an enabled window in the pair picked by the access kind
    assert_enabled_pair_R6: assert property (@(posedge clk) disable iff (rst)
        hit |-> pair_has_enabled);

    assert_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((phys_addr & ~LOW_MASK) == (acc_addr & ~LOW_MASK)) && ((phys_addr & LOW_MASK) == '0));

    assert_read_exec_R9: assert property (@(posedge clk) disable iff (rst)
        hit |-> (perm_r && perm_x));

    assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (!perm_r && !perm_w && !perm_x && phys_addr == '0));

    assert_write_grant_R10: assert property (@(posedge clk) disable iff (rst)
        perm_w |-> (hit && pair_has_writable));

endmodule

bind tt_xlate_matcher tt_xlate_matcher_chk #(
    .PAGE_BITS    (PAGE_BITS),
    .WIN_PER_KIND (WIN_PER_KIND),
    .SEL_W        (SEL_W)
) u_chk (.*);

// File: tb/tb_tt_xlate_matcher.sv
module tb_tt_xlate_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cr_wr_en = 1'b0;
    logic [1:0]  cr_sel = '0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic [31:0] acc_addr = '0;
    logic        acc_super = 1'b0;
    logic        acc_ifetch = 1'b0;
    logic        hit;
    logic [31:0] phys_addr;
    logic        perm_r, perm_w, perm_x;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_read;
        logic [31:0] rdata;
        logic        hit;
        logic [31:0] phys;
        logic        w;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    tt_xlate_matcher dut (
        .clk(clk), .rst(rst), .cr_wr_en(cr_wr_en), .cr_sel(cr_sel),
        .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .acc_addr(acc_addr),
        .acc_super(acc_super), .acc_ifetch(acc_ifetch), .hit(hit),
        .phys_addr(phys_addr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    localparam logic [1:0] DW0 = 2'd0, DW1 = 2'd1, IW0 = 2'd2, IW1 = 2'd3;

    function automatic logic [31:0] mkwin(input logic [7:0] base, input logic [7:0] dc,
                                          input logic en, input logic [1:0] pr, input logic wp);
        return {base, dc, en, pr, 10'b0, wp, 2'b0};
    endfunction

    function automatic exp_t mk_look(input logic h, input logic [31:0] a, input logic wr_ok, input string req);
        exp_t e;
        e.is_read = 1'b0;
        e.rdata   = '0;
        e.hit     = h;
        e.phys    = h ? {a[31:12], 12'h000} : 32'h0;
        e.w       = h && wr_ok;
        e.req     = req;
        return e;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_sel = sel; cr_wdata = data;
        @(negedge clk);
        cr_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp_v, input string req);
        exp_t e;
        @(negedge clk);
        cr_sel = sel;
        e.is_read = 1'b1; e.rdata = exp_v; e.hit = 1'b0; e.phys = '0; e.w = 1'b0; e.req = req;
        sb.push_back(e);
    endtask

    task automatic look(input logic [31:0] a, input logic sup, input logic ifetch,
                        input logic exp_hit, input logic exp_w, input string req);
        @(negedge clk);
        acc_addr = a; acc_super = sup; acc_ifetch = ifetch;
        sb.push_back(mk_look(exp_hit, a, exp_w, req));
    endtask

    // monitor: compare 3 ns after the falling edge, clear of the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.is_read) begin
                    if (cr_rdata !== e.rdata) begin
                        failures++;
                        $display("FAIL %s: cr_rdata=%h expected %h", e.req, cr_rdata, e.rdata);
                    end
                end else begin
                    if (hit !== e.hit || phys_addr !== e.phys || perm_r !== e.hit ||
                        perm_x !== e.hit || perm_w !== e.w) begin
                        failures++;
                        $display("FAIL %s: hit=%b phys=%h r=%b w=%b x=%b expected hit=%b phys=%h r=%b w=%b x=%b",
                                 e.req, hit, phys_addr, perm_r, perm_w, perm_x,
                                 e.hit, e.phys, e.hit, e.w, e.hit);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        rd(DW0, 32'h0, "R2 reset DW0");
        rd(DW1, 32'h0, "R2 reset DW1");
        rd(IW0, 32'h0, "R2 reset IW0");
        rd(IW1, 32'h0, "R2 reset IW1");
        look(32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, "R2 data miss after reset");
        look(32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, "R2 fetch miss after reset");

        // R1: write and read back, distinct values per selector
        wr(DW0, 32'hA5A5_0004);
        wr(IW1, 32'h3C3C_1234);
        rd(DW0, 32'hA5A5_0004, "R1 readback DW0");
        rd(IW1, 32'h3C3C_1234, "R1 readback IW1");
        rd(DW1, 32'h0, "R1 DW1 untouched");
        wr(IW1, 32'h0);

        // R5/R8/R9/R10: exact base 0x40, both modes, writable
        wr(DW0, mkwin(8'h40, 8'h00, 1'b1, 2'b10, 1'b0));
        look(32'h40AB_CDEF, 1'b0, 1'b0, 1'b1, 1'b1, "R8 R9 R10 hit user passthrough");
        look(32'h40FF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1, "R5 low bits ignored, super");
        look(32'h4100_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R5 top byte differs miss");
        look(32'h40AB_CDEF, 1'b0, 1'b1, 1'b0, 1'b0, "R6 fetch ignores data window");

        // R3: disabled window
        wr(DW0, mkwin(8'h40, 8'h00, 1'b0, 2'b10, 1'b0));
        look(32'h40AB_CDEF, 1'b0, 1'b0, 1'b0, 1'b0, "R3 disabled window misses");

        // R4: privilege filter
        wr(DW0, mkwin(8'h40, 8'h00, 1'b1, 2'b00, 1'b0));
        look(32'h4000_1000, 1'b0, 1'b0, 1'b1, 1'b1, "R4 user-only user hit");
        look(32'h4000_1000, 1'b1, 1'b0, 1'b0, 1'b0, "R4 user-only super miss");
        wr(DW0, mkwin(8'h40, 8'h00, 1'b1, 2'b01, 1'b0));
        look(32'h4000_1000, 1'b0, 1'b0, 1'b0, 1'b0, "R4 super-only user miss");
        look(32'h4000_1000, 1'b1, 1'b0, 1'b1, 1'b1, "R4 super-only super hit");
        wr(DW0, mkwin(8'h40, 8'h00, 1'b1, 2'b11, 1'b0));
        look(32'h4000_1000, 1'b0, 1'b0, 1'b1, 1'b1, "R4 mode 11 user hit");
        look(32'h4000_1000, 1'b1, 1'b0, 1'b1, 1'b1, "R4 mode 11 super hit");

        // R5: don't-care mask
        wr(DW0, mkwin(8'h85, 8'h0F, 1'b1, 2'b10, 1'b0));
        look(32'h8F12_3456, 1'b0, 1'b0, 1'b1, 1'b1, "R5 masked bits don't care");
        look(32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, "R5 base bits under mask ignored");
        look(32'h9000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R5 unmasked bit differs miss");

        // R7/R10: priority within data pair
        wr(DW0, mkwin(8'h20, 8'h00, 1'b1, 2'b10, 1'b1));
        wr(DW1, mkwin(8'h20, 8'h00, 1'b1, 2'b10, 1'b0));
        look(32'h2000_0ABC, 1'b0, 1'b0, 1'b1, 1'b0, "R7 R10 window 0 wins, write protected");
        wr(DW0, mkwin(8'h20, 8'h00, 1'b0, 2'b10, 1'b1));
        look(32'h2000_0ABC, 1'b0, 1'b0, 1'b1, 1'b1, "R7 window 1 used when 0 disabled");

        // R6: instruction pair only
        wr(IW1, mkwin(8'hF0, 8'h00, 1'b1, 2'b10, 1'b1));
        look(32'hF000_1234, 1'b1, 1'b1, 1'b1, 1'b0, "R6 fetch hits IW1");
        look(32'hF000_1234, 1'b1, 1'b0, 1'b0, 1'b0, "R6 data ignores IW1");
        look(32'h2000_0ABC, 1'b0, 1'b1, 1'b0, 1'b0, "R6 fetch ignores DW1");

        // R11: write and lookup in the same cycle
        @(negedge clk);
        cr_wr_en = 1'b1; cr_sel = IW0; cr_wdata = mkwin(8'h55, 8'h00, 1'b1, 2'b10, 1'b0);
        acc_addr = 32'h5500_7777; acc_super = 1'b0; acc_ifetch = 1'b1;
        sb.push_back(mk_look(1'b0, 32'h5500_7777, 1'b0, "R11 lookup sees old contents"));
        @(negedge clk);
        cr_wr_en = 1'b0;
        sb.push_back(mk_look(1'b1, 32'h5500_7777, 1'b1, "R11 new contents next cycle"));

        // R11: rewrite priority window while both cover the address
        @(negedge clk);
        cr_wr_en = 1'b1; cr_sel = DW0; cr_wdata = mkwin(8'h20, 8'h00, 1'b1, 2'b10, 1'b1);
        acc_addr = 32'h2000_0010; acc_super = 1'b1; acc_ifetch = 1'b0;
        sb.push_back(mk_look(1'b1, 32'h2000_0010, 1'b1, "R11 R7 old window 1 permission"));
        @(negedge clk);
        cr_wr_en = 1'b0;
        sb.push_back(mk_look(1'b1, 32'h2000_0010, 1'b0, "R11 R7 new window 0 permission"));

        @(negedge clk);
        #5;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule